// File: doc/BRIEF.md
# 8080-Style Parallel Display Write Controller

This block drives a write-only parallel display bus of the 8080 style: a chip select, a D/C (command versus data) line, a write strobe and a data bus that carries 8 or 16 lines. A streaming input hands it one item at a time. Each item is a command word, a parameter word, a dummy beat or a 16-bit colour word. The block splits each item into bus beats, raises the strobe with a 50% duty cycle from an integer divider of the system clock, and sets D/C to a separate programmed level for each phase.

Several items make one transaction. The item flagged as last closes it. Chip select is active for the whole transaction. When the transaction carried colour data, a one-cycle completion pulse follows once the bus is idle again. Polarity, strobe edge, strobe rest level, colour bit mirroring and colour byte exchange are all live configuration inputs. They may change only while the block is idle.

Top module: `pdw_top`

## Requirements
- R1: Every beat holds the strobe at its pre-latch level for exactly `cfg_div` system clocks and then at the opposite level for `cfg_div` clocks. A `cfg_div` of 0 is an unreachable rate: `cfg_err` is 1, `in_ready` is 0 and no item is taken.
- R2: With `cfg_bus16`=0 each beat carries one byte on `lcd_dat[7:0]` and `lcd_dat[15:8]` is 0. With `cfg_bus16`=1 each beat carries 16 bits.
- R3: `lcd_dc` follows `cfg_dc_lvl`. Bit 0 applies when idle, bit 1 to command beats, bit 2 to dummy beats, and bit 3 to parameter and colour beats.
- R4: With `cfg_cs_use`=1, `lcd_cs` is at the active level during a transaction and at the opposite level when idle. `cfg_cs_high`=1 makes the active level high. With `cfg_cs_use`=0, `lcd_cs` stays at the active level at all times.
- R5: A command is `cfg_cmd_len`+1 bytes and a parameter is `cfg_par_len`+1 bytes, both taken from the low end of `in_word`. Higher bits are ignored. On a 16-bit bus an odd byte count is zero-extended at the top. Beats go out most significant first.
- R6: With `cfg_byte_swap`=1 the two bytes of a colour word (`in_word[15:0]`) are exchanged. On an 8-bit bus the upper byte of the resulting word goes first. Commands and parameters are never swapped.
- R7: With `cfg_bit_rev`=1 every colour beat is mirrored across the active bus width, so bit N-1 goes to bit 0. Commands, parameters and dummy beats are never mirrored.
- R8: The latching strobe edge is rising when `cfg_latch_fall`=0 and falling when it is 1. `lcd_dat` and `lcd_dc` never change on a latching edge.
- R9: When no transaction is active the strobe rests high, or low when `cfg_wr_idle_low`=1.
- R10: One cycle after the final beat's trailing half ends, `xfer_done` pulses for exactly one cycle if the transaction held colour data. In that cycle chip select is already inactive. Transactions without colour produce no pulse.
- R11: `in_kind` encodes 0 = command, 1 = parameter, 2 = dummy (one zero beat), 3 = colour. The item with `in_last`=1 closes the transaction. An item is taken when `in_valid` and `in_ready` are both high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Strobe half-period in system clocks |
| cfg_bus16 | input | 1 | 1 = 16-line bus, 0 = 8-line bus |
| cfg_cmd_len | input | IDX_W | Command bytes minus one |
| cfg_par_len | input | IDX_W | Parameter bytes minus one |
| cfg_dc_lvl | input | 4 | D/C level for idle, command, dummy, data |
| cfg_cs_use | input | 1 | Chip select toggles per transaction |
| cfg_cs_high | input | 1 | Chip select is active high |
| cfg_latch_fall | input | 1 | Display latches on the falling strobe edge |
| cfg_wr_idle_low | input | 1 | Strobe rests low when idle |
| cfg_bit_rev | input | 1 | Mirror colour beats |
| cfg_byte_swap | input | 1 | Exchange colour bytes |
| cfg_err | output | 1 | Divider setting cannot be met |
| in_valid | input | 1 | Item present |
| in_ready | output | 1 | Item can be taken |
| in_kind | input | 2 | Item kind |
| in_word | input | WORD_W | Item value |
| in_last | input | 1 | Item closes the transaction |
| lcd_cs | output | 1 | Chip select |
| lcd_dc | output | 1 | Command/data select |
| lcd_wr | output | 1 | Write strobe |
| lcd_dat | output | 16 | Data bus |
| xfer_done | output | 1 | Colour transaction complete pulse |

## Verification
The bench sweeps bus width, mirroring, byte exchange, latch edge, strobe rest level, three chip-select modes, three divider values and all command and parameter lengths. It records each beat at the latching edge and compares it against values computed from the requirements. The risky corners are odd byte counts on the 16-bit bus, where a wrong pad would shift every beat; mirroring or exchange leaking into commands, which would scramble register addresses; and data moving on the latching edge, which the display would sample mid-change. It also checks a mis-timed completion pulse that fires while chip select is still active, or that fires for a command-only transaction, and it checks that a zero divider is refused rather than run at a bogus rate.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

    typedef enum logic [1:0] {
        K_CMD    = 2'd0,
        K_PARAM  = 2'd1,
        K_DUMMY  = 2'd2,
        K_COLOUR = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_TRAIL = 2'd2,
        PH_GAP   = 2'd3
    } phase_e;

endpackage

// File: rtl/pdw_bit_mirror.sv
module pdw_bit_mirror (
    input  logic        wide_i,
    input  logic [15:0] d_i,
    output logic [15:0] q_o
);
    logic [15:0] full;
    logic [7:0]  half;

    for (genvar i = 0; i < 16; i++) begin : g_full
        assign full[i] = d_i[15 - i];
    end
    for (genvar j = 0; j < 8; j++) begin : g_half
        assign half[j] = d_i[7 - j];
    end

    assign q_o = wide_i ? full : {8'h00, half};
endmodule

// File: rtl/pdw_beat_plan.sv
module pdw_beat_plan
    import pdw_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned IDX_W  = 2
) (
    input  kind_e              kind_i,
    input  logic [WORD_W-1:0]  word_i,
    input  logic               first_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               bus16_i,
    input  logic [IDX_W-1:0]   cmd_len_i,
    input  logic [IDX_W-1:0]   par_len_i,
    input  logic               bit_rev_i,
    input  logic               byte_swap_i,
    output logic [IDX_W-1:0]   last_idx_o,
    output logic [15:0]        beat_o
);
    localparam int unsigned BYTES = WORD_W / 8;

    logic [IDX_W-1:0]  blen;
    logic [IDX_W-1:0]  sel;
    logic [15:0]       col;
    logic [WORD_W-1:0] masked;
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] shifted;
    logic [15:0]       raw;
    logic [15:0]       mir;

    always_comb begin
        case (kind_i)
            K_CMD:   blen = cmd_len_i;
            K_PARAM: blen = par_len_i;
            K_DUMMY: blen = '0;
            default: blen = IDX_W'(1);
        endcase
    end

    assign last_idx_o = bus16_i ? (blen >> 1) : blen;
    assign sel        = first_i ? last_idx_o : idx_i;
    assign col        = byte_swap_i ? {word_i[7:0], word_i[15:8]} : word_i[15:0];

    always_comb begin
        for (int b = 0; b < int'(BYTES); b++) begin
            masked[8*b +: 8] = (b <= int'(blen)) ? word_i[8*b +: 8] : 8'h00;
        end
    end

    always_comb begin
        case (kind_i)
            K_COLOUR: src = WORD_W'(col);
            K_DUMMY:  src = '0;
            default:  src = masked;
        endcase
    end

    assign shifted = src >> (bus16_i ? {sel, 4'b0000} : {1'b0, sel, 3'b000});
    assign raw     = bus16_i ? shifted[15:0] : {8'h00, shifted[7:0]};

    pdw_bit_mirror u_mirror (
        .wide_i (bus16_i),
        .d_i    (raw),
        .q_o    (mir)
    );

    assign beat_o = (kind_i == K_COLOUR && bit_rev_i) ? mir : raw;
endmodule

// File: rtl/pdw_top.sv
module pdw_top
    import pdw_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned DIV_W  = 8,
    localparam int unsigned IDX_W = (WORD_W / 8 > 2) ? $clog2(WORD_W / 8) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_bus16,
    input  logic [IDX_W-1:0]  cfg_cmd_len,
    input  logic [IDX_W-1:0]  cfg_par_len,
    input  logic [3:0]        cfg_dc_lvl,
    input  logic              cfg_cs_use,
    input  logic              cfg_cs_high,
    input  logic              cfg_latch_fall,
    input  logic              cfg_wr_idle_low,
    input  logic              cfg_bit_rev,
    input  logic              cfg_byte_swap,
    output logic              cfg_err,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_kind,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_last,
    output logic              lcd_cs,
    output logic              lcd_dc,
    output logic              lcd_wr,
    output logic [15:0]       lcd_dat,
    output logic              xfer_done
);
    typedef struct packed {
        phase_e            ph;
        logic [DIV_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        kind_e             kind;
        logic [WORD_W-1:0] word;
        logic              last;
        logic              had_col;
        logic [15:0]       dat;
        logic              done;
    } st_t;

    st_t s_q, s_d;

    logic              take;
    kind_e             plan_kind;
    logic [WORD_W-1:0] plan_word;
    logic [IDX_W-1:0]  plan_last;
    logic [15:0]       plan_beat;
    logic              pre_lvl;

    assign cfg_err   = (cfg_div == '0);
    assign in_ready  = !cfg_err && (s_q.ph == PH_IDLE || s_q.ph == PH_GAP);
    assign take      = in_valid && in_ready;
    assign plan_kind = take ? kind_e'(in_kind) : s_q.kind;
    assign plan_word = take ? in_word : s_q.word;
    assign pre_lvl   = cfg_latch_fall;

    pdw_beat_plan #(
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_plan (
        .kind_i      (plan_kind),
        .word_i      (plan_word),
        .first_i     (take),
        .idx_i       (s_q.idx - IDX_W'(1)),
        .bus16_i     (cfg_bus16),
        .cmd_len_i   (cfg_cmd_len),
        .par_len_i   (cfg_par_len),
        .bit_rev_i   (cfg_bit_rev),
        .byte_swap_i (cfg_byte_swap),
        .last_idx_o  (plan_last),
        .beat_o      (plan_beat)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.ph)
            PH_IDLE, PH_GAP: begin
                if (take) begin
                    s_d.ph      = PH_LEAD;
                    s_d.cnt     = cfg_div - DIV_W'(1);
                    s_d.idx     = plan_last;
                    s_d.kind    = kind_e'(in_kind);
                    s_d.word    = in_word;
                    s_d.last    = in_last;
                    s_d.had_col = (s_q.ph == PH_GAP && s_q.had_col) ||
                                  (in_kind == K_COLOUR);
                    s_d.dat     = plan_beat;
                end
            end
            PH_LEAD: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_TRAIL;
                    s_d.cnt = cfg_div - DIV_W'(1);
                end else begin
                    s_d.cnt = s_q.cnt - DIV_W'(1);
                end
            end
            default: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - DIV_W'(1);
                end else if (s_q.idx != '0) begin
                    s_d.ph  = PH_LEAD;
                    s_d.cnt = cfg_div - DIV_W'(1);
                    s_d.idx = s_q.idx - IDX_W'(1);
                    s_d.dat = plan_beat;
                end else if (s_q.last) begin
                    s_d.ph      = PH_IDLE;
                    s_d.done    = s_q.had_col;
                    s_d.had_col = 1'b0;
                end else begin
                    s_d.ph = PH_GAP;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, kind: K_CMD, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (s_q.ph)
            PH_IDLE:  lcd_wr = !cfg_wr_idle_low;
            PH_LEAD:  lcd_wr = pre_lvl;
            default:  lcd_wr = !pre_lvl;
        endcase
        if (s_q.ph == PH_IDLE) begin
            lcd_dc = cfg_dc_lvl[0];
        end else begin
            case (s_q.kind)
                K_CMD:   lcd_dc = cfg_dc_lvl[1];
                K_DUMMY: lcd_dc = cfg_dc_lvl[2];
                default: lcd_dc = cfg_dc_lvl[3];
            endcase
        end
    end

    assign lcd_cs    = (cfg_cs_use && s_q.ph == PH_IDLE) ? !cfg_cs_high : cfg_cs_high;
    assign lcd_dat   = s_q.dat;
    assign xfer_done = s_q.done;
endmodule

// File: rtl/pdw_checks.sv
module pdw_checks #(
    parameter int unsigned DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] cfg_div,
    input logic             cfg_bus16,
    input logic [3:0]       cfg_dc_lvl,
    input logic             cfg_cs_use,
    input logic             cfg_cs_high,
    input logic             cfg_latch_fall,
    input logic             cfg_wr_idle_low,
    input logic             cfg_err,
    input logic             in_ready,
    input logic             lcd_cs,
    input logic             lcd_dc,
    input logic             lcd_wr,
    input logic [15:0]      lcd_dat,
    input logic             xfer_done
);
    // R1: a zero divider is refused
    assert_zero_div_refused_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_div == '0) |-> (cfg_err && !in_ready));

    // R8: nothing on the bus moves on a latching edge
    assert_stable_on_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_wr != $past(lcd_wr) && lcd_wr == !cfg_latch_fall &&
         $stable(cfg_latch_fall) && $stable(cfg_wr_idle_low) && $stable(cfg_dc_lvl))
        |-> ($stable(lcd_dat) && $stable(lcd_dc)));

    // R2: narrow bus leaves the top byte at zero when latched
    assert_narrow_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_bus16 && lcd_wr != $past(lcd_wr) && lcd_wr == !cfg_latch_fall &&
         $stable(cfg_latch_fall) && $stable(cfg_wr_idle_low) && $stable(cfg_bus16))
        |-> (lcd_dat[15:8] == 8'h00));

    // R4: chip select is active whenever a beat is latched
    assert_cs_active_on_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_wr != $past(lcd_wr) && lcd_wr == !cfg_latch_fall &&
         $stable(cfg_latch_fall) && $stable(cfg_wr_idle_low))
        |-> (lcd_cs == cfg_cs_high));

    // R10: completion pulse is one cycle wide
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R10: completion pulse only once chip select is released
    assert_done_cs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && cfg_cs_use) |-> (lcd_cs == !cfg_cs_high));

    // R9: strobe is at its rest level whenever a colour transfer completes
    assert_done_wr_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (lcd_wr == !cfg_wr_idle_low));
endmodule

bind pdw_top pdw_checks #(.DIV_W(DIV_W)) u_checks (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_div         (cfg_div),
    .cfg_bus16       (cfg_bus16),
    .cfg_dc_lvl      (cfg_dc_lvl),
    .cfg_cs_use      (cfg_cs_use),
    .cfg_cs_high     (cfg_cs_high),
    .cfg_latch_fall  (cfg_latch_fall),
    .cfg_wr_idle_low (cfg_wr_idle_low),
    .cfg_err         (cfg_err),
    .in_ready        (in_ready),
    .lcd_cs          (lcd_cs),
    .lcd_dc          (lcd_dc),
    .lcd_wr          (lcd_wr),
    .lcd_dat         (lcd_dat),
    .xfer_done       (xfer_done)
);

// File: tb/pdw_top_bench.sv
module pdw_top_bench;
    localparam int WORD_W = 32;
    localparam int DIV_W  = 8;
    localparam int IDX_W  = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic [DIV_W-1:0]  cfg_div;
    logic              cfg_bus16, cfg_cs_use, cfg_cs_high, cfg_latch_fall;
    logic              cfg_wr_idle_low, cfg_bit_rev, cfg_byte_swap, cfg_err;
    logic [IDX_W-1:0]  cfg_cmd_len, cfg_par_len;
    logic [3:0]        cfg_dc_lvl;
    logic              in_valid, in_ready, in_last;
    logic [1:0]        in_kind;
    logic [WORD_W-1:0] in_word;
    logic              lcd_cs, lcd_dc, lcd_wr, xfer_done;
    logic [15:0]       lcd_dat;

    pdw_top #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_pdw_top (.*);

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [15:0] e_dat [64];
    logic        e_dc  [64];
    string       e_req [64];
    int          n_exp;
    logic [15:0] g_dat [64];
    logic        g_dc  [64];
    logic        g_cs  [64];
    int          n_got;
    int          n_done;
    logic        prev_wr;
    int          a_len;
    bit          a_on;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R11 watchdog: actual %0d expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // beat monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (lcd_wr != prev_wr && lcd_wr == !cfg_latch_fall) begin
                if (n_got < 64) begin
                    g_dat[n_got] = lcd_dat;
                    g_dc[n_got]  = lcd_dc;
                    g_cs[n_got]  = lcd_cs;
                end
                n_got++;
                if (a_on) chk(a_len == int'(cfg_div), "R1", "lead half length", a_len, int'(cfg_div));
                a_on = 1'b0;
            end else if (lcd_wr != prev_wr && lcd_wr == cfg_latch_fall) begin
                a_on  = 1'b1;
                a_len = 1;
            end else if (a_on) begin
                a_len++;
            end
            if (xfer_done) begin
                n_done++;
                if (cfg_cs_use)
                    chk(lcd_cs == !cfg_cs_high, "R10", "cs at done", int'(lcd_cs), int'(!cfg_cs_high));
            end
        end
        prev_wr = lcd_wr;
    end

    function automatic logic [15:0] mirror(input logic [15:0] d, input int w);
        logic [15:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = d[w - 1 - i];
        return r;
    endfunction

    task automatic push(input logic [15:0] d, input logic dc, input string req);
        if (n_exp < 64) begin
            e_dat[n_exp] = d;
            e_dc[n_exp]  = dc;
            e_req[n_exp] = req;
        end
        n_exp++;
    endtask

    task automatic add_exp(input logic [1:0] k, input logic [31:0] w);
        int bytes, nb, bw;
        logic [15:0] c;
        logic [31:0] m;
        bw = cfg_bus16 ? 16 : 8;
        if (k == 2'd3) begin
            c = w[15:0];
            if (cfg_byte_swap) c = {c[7:0], c[15:8]};
            if (cfg_bus16) begin
                push(cfg_bit_rev ? mirror(c, 16) : c, cfg_dc_lvl[3], "R6/R7");
            end else begin
                push(cfg_bit_rev ? mirror({8'h0, c[15:8]}, 8) : {8'h0, c[15:8]}, cfg_dc_lvl[3], "R6/R7");
                push(cfg_bit_rev ? mirror({8'h0, c[7:0]}, 8) : {8'h0, c[7:0]}, cfg_dc_lvl[3], "R6/R7");
            end
        end else if (k == 2'd2) begin
            push(16'h0000, cfg_dc_lvl[2], "R11");
        end else begin
            bytes = (k == 2'd0) ? int'(cfg_cmd_len) + 1 : int'(cfg_par_len) + 1;
            m = (bytes == 4) ? w : (w & ((32'h1 << (8 * bytes)) - 1));
            nb = cfg_bus16 ? (bytes + 1) / 2 : bytes;
            for (int i = 0; i < nb; i++)
                push(16'((m >> (bw * (nb - 1 - i))) & ((32'h1 << bw) - 1)),
                     (k == 2'd0) ? cfg_dc_lvl[1] : cfg_dc_lvl[3], "R5");
        end
    endtask

    task automatic send(input logic [1:0] k, input logic [31:0] w, input bit last);
        add_exp(k, w);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_word = w; in_last = last;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_txn(input bit with_col, input int iter);
        logic [31:0] seed;
        seed = (32'(iter) * 32'h9E37_79B9) ^ 32'h5A5A_C3C3;
        @(posedge clk);
        n_exp = 0; n_got = 0; n_done = 0; a_on = 1'b0;
        send(2'd0, seed, 1'b0);
        send(2'd1, seed * 32'd13 + 32'h0F1E_2D3C, 1'b0);
        send(2'd2, seed ^ 32'hFFFF_FFFF, 1'b0);
        if (with_col) begin
            send(2'd3, seed * 32'd7 + 32'h0000_81C3, 1'b0);
            send(2'd3, seed ^ 32'h1234_A55A, 1'b1);
        end else begin
            send(2'd1, seed * 32'd5 + 32'h0102_0304, 1'b1);
        end
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(n_got == n_exp, "R5", "beat count", n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got && i < 64; i++) begin
            chk(g_dat[i] == e_dat[i], e_req[i], "beat data", int'(g_dat[i]), int'(e_dat[i]));
            chk(g_dc[i] == e_dc[i], "R3", "beat dc", int'(g_dc[i]), int'(e_dc[i]));
            chk(g_cs[i] == cfg_cs_high, "R4", "cs during beat", int'(g_cs[i]), int'(cfg_cs_high));
            if (!cfg_bus16) chk(g_dat[i][15:8] == 8'h00, "R2", "narrow top byte", int'(g_dat[i][15:8]), 0);
        end
        chk(n_done == int'(with_col), "R10", "done pulses", n_done, int'(with_col));
        chk(lcd_wr == !cfg_wr_idle_low, "R9", "strobe rest", int'(lcd_wr), int'(!cfg_wr_idle_low));
        chk(lcd_dc == cfg_dc_lvl[0], "R3", "idle dc", int'(lcd_dc), int'(cfg_dc_lvl[0]));
        chk(lcd_cs == (cfg_cs_use ? !cfg_cs_high : cfg_cs_high), "R4", "idle cs",
            int'(lcd_cs), int'(cfg_cs_use ? !cfg_cs_high : cfg_cs_high));
    endtask

    initial begin
        rst_n = 1'b0; cfg_div = 8'd2; cfg_bus16 = 1'b0; cfg_cs_use = 1'b1; cfg_cs_high = 1'b0;
        cfg_latch_fall = 1'b0; cfg_wr_idle_low = 1'b0; cfg_bit_rev = 1'b0; cfg_byte_swap = 1'b0;
        cfg_cmd_len = '0; cfg_par_len = '0; cfg_dc_lvl = 4'b1010;
        in_valid = 1'b0; in_kind = '0; in_word = '0; in_last = 1'b0;
        n_exp = 0; n_got = 0; n_done = 0; a_on = 1'b0; a_len = 0; prev_wr = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R11", "reset ready", int'(in_ready), 1);
        chk(lcd_wr == 1'b1, "R9", "reset strobe", int'(lcd_wr), 1);
        chk(lcd_cs == 1'b1, "R4", "reset cs", int'(lcd_cs), 1);
        chk(lcd_dc == 1'b0, "R3", "reset dc", int'(lcd_dc), 0);
        chk(xfer_done == 1'b0, "R10", "reset done", int'(xfer_done), 0);

        // R1: zero divider is refused and nothing moves
        cfg_div = 8'd0;
        in_valid = 1'b1; in_kind = 2'd3; in_word = 32'hBEEF; in_last = 1'b1;
        @(negedge clk);
        chk(cfg_err == 1'b1, "R1", "zero divider error", int'(cfg_err), 1);
        chk(in_ready == 1'b0, "R1", "zero divider ready", int'(in_ready), 0);
        repeat (5) @(negedge clk);
        chk(lcd_wr == 1'b1 && lcd_cs == 1'b1, "R1", "bus still idle", int'({lcd_wr, lcd_cs}), 3);
        in_valid = 1'b0;
        cfg_div = 8'd2;
        @(negedge clk);
        chk(cfg_err == 1'b0, "R1", "valid divider error", int'(cfg_err), 0);

        for (int iter = 0; iter < 64; iter++) begin
            @(negedge clk);
            cfg_bus16       = iter[0];
            cfg_bit_rev     = iter[1];
            cfg_byte_swap   = iter[2];
            cfg_latch_fall  = iter[3];
            cfg_wr_idle_low = iter[4];
            cfg_div         = 8'(((iter >> 4) % 3) + 1);
            cfg_cmd_len     = 2'(iter % 4);
            cfg_par_len     = 2'((iter >> 2) % 4);
            cfg_cs_use      = (iter % 3) != 2;
            cfg_cs_high     = (iter % 3) == 0;
            cfg_dc_lvl      = 4'(iter * 7 + 5);
            repeat (2) @(negedge clk);
            run_txn(1'b1, iter);
            run_txn(1'b0, iter + 100);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule